// File: doc/BRIEF.md
# Serialized Interrupt Slave Agent

This block is the peripheral end of a serialized interrupt link. It reports up to three interrupt sources to a host over one shared, pulled-up serial interrupt line, and everything runs on the LPC clock. Two of the sources have fixed positions: a keyboard slot at IRQ1 and a mouse slot at IRQ12. The third source can be placed in any IRQ1..IRQ15 slot or in one of eleven extended frames. Each source is active when its software request bit is set, or when the buffer-full flag that feeds it is 1 and its hardware enable is set.

The agent follows the line through its start, data-frame and stop phases. At the start frame it captures the levels of its sources. In each data frame it drives the sample clock of each slot it owns, and it reads the stop frame to choose between continuous and quiet operation. In quiet mode it can begin a cycle itself by pulling the line low for one clock. It also drives the clock-run line low, either to ask for a stopped clock to restart or to hold off a clock stop while a serial cycle is in progress.

Top module: `sirq_agent`

## Requirements
- R1: After reset, the agent releases the serial line (`serirq_oe`=0) and the clock-run line (`clkrun_drive`=0), and it starts in continuous mode.
- R2: The IRQ1 source level is `soft_req[0] | (obuf_full0 & hw_en[0])`.
- R3: The IRQ12 source level is `soft_req[1] | (obuf_full0 & hw_en[1])`.
- R4: The third source level is `soft_req[2] | (obuf_full1 & hw_en[2])`. Its slot is `user_sel`: values 1..15 select IRQ slots 1..15, values 16..26 select extended frames 0..10 (slot 16+n), and values 0 and 27..31 select no slot.
- R5: A start frame is recognised only when the line is sampled low for 4 to 8 consecutive clocks. The sample clock of slot 0 is the second clock with the line high, and slot s occupies the three clocks that begin 3*s clocks later. A low run of 3 or of 9 clocks starts no frames.
- R6: Each slot has three clocks: sample, recovery and turnaround. In the sample clock of an owned slot whose level is 0, the agent drives the line low. In the recovery clock of that slot it drives the line high. In the turnaround clock it releases the line. The agent never drives a slot it does not own, and never drives an owned slot whose level is 1.
- R7: Source levels and the slot selection are captured when the start frame ends and are held for the whole cycle. A change made during frames shows up in the next cycle.
- R8: A stop frame of 2 low clocks selects quiet mode. A stop frame of 3 or more low clocks selects continuous mode.
- R9: In quiet mode, when the line is idle and any source level differs from the last reported level, the agent drives the line low for exactly one clock. In continuous mode it never does this.
- R10: When `restart_en`=1, a level differs from the last reported level and `clkrun_in` is high, the agent drives `clkrun_drive`=1 from the next clock. It keeps driving until that condition is withdrawn, even after `clkrun_in` falls, and it never starts driving while `clkrun_in` is low.
- R11: When `stop_inh_en`=1 and `clkrun_in` is high, the agent drives `clkrun_drive`=1 while a serial cycle is in progress, and releases it once the line is idle again.
- R12: When the third source shares slot 1 or slot 12, the slot level is the OR of the sources that own it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_req | input | 3 | Software requests: [0] IRQ1, [1] IRQ12, [2] user slot |
| obuf_full0 | input | 1 | Buffer-full flag feeding IRQ1 and IRQ12 |
| obuf_full1 | input | 1 | Buffer-full flag feeding the user slot |
| hw_en | input | 3 | Hardware enables, same bit order as soft_req |
| user_sel | input | 5 | Slot selector for the user source |
| restart_en | input | 1 | Enables the clock-restart request |
| stop_inh_en | input | 1 | Enables the clock-stop hold-off during a cycle |
| serirq_in | input | 1 | Sampled level of the serial interrupt line |
| serirq_oe | output | 1 | Serial line drive enable |
| serirq_out | output | 1 | Serial line drive value when enabled |
| clkrun_in | input | 1 | Sampled level of the clock-run line |
| clkrun_drive | output | 1 | Drive the clock-run line low |

## Verification
The bench uses the default parameters: keyboard slot 1, mouse slot 12 and a start window of 4 to 8 clocks. With these values both edges of the start window, the invalid runs just outside it, and the full span of 27 slots up to extended frame 10 all fit within a few hundred clocks per cycle. The keyboard and mouse defaults also make slot collisions with the user selector reachable by setting `user_sel` to 1 or 12.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int IRQ_SLOTS   = 16;
  localparam int EXT_FRAMES  = 11;
  localparam int TOTAL_SLOTS = IRQ_SLOTS + EXT_FRAMES;
  localparam int SLOT_W      = $clog2(TOTAL_SLOTS);
  localparam int NUM_SRC     = 3;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KICK, ST_START, ST_FRAME, ST_STOPW, ST_STOP
  } sirq_state_e;

  // selector value equals slot index; zero means "no slot"
  function automatic slot_t user_slot(input logic [4:0] sel);
    if (sel != 5'd0 && int'(sel) < TOTAL_SLOTS) return slot_t'(sel);
    return '0;
  endfunction

  function automatic logic slot_owned(input slot_t s, input slot_t usr,
                                      input slot_t kbd, input slot_t mse);
    return (s == kbd) || (s == mse) || (usr != '0 && s == usr);
  endfunction

  function automatic logic slot_level(input slot_t s, input slot_t usr,
                                      input slot_t kbd, input slot_t mse,
                                      input logic [NUM_SRC-1:0] lv);
    return (lv[0] && s == kbd) || (lv[1] && s == mse) ||
           (lv[2] && usr != '0 && s == usr);
  endfunction
endpackage

// File: rtl/sirq_req_merge.sv
module sirq_req_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] soft_req,
  input  logic [N-1:0] hw_en,
  input  logic [N-1:0] flag_src,
  output logic [N-1:0] level
);
  for (genvar i = 0; i < N; i++) begin : g_src
    assign level[i] = soft_req[i] | (flag_src[i] & hw_en[i]);
  end
endmodule

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_pkg::*;
#(
  parameter int START_MIN = 4,
  parameter int START_MAX = 8,
  parameter int LAST_SLOT = TOTAL_SLOTS - 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  input  logic        change,
  output sirq_state_e st,
  output slot_t       slot,
  output logic [1:0]  phase,
  output logic        quiet,
  output logic        start_hit
);
  localparam int CNT_W = $clog2(START_MAX + 2);
  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(START_MAX);
  localparam logic [CNT_W-1:0] SAT_C  = '1;
  localparam slot_t            LAST_C = slot_t'(LAST_SLOT);

  logic [CNT_W-1:0] lowcnt;
  logic [CNT_W-1:0] lowcnt_inc;

  assign lowcnt_inc = (lowcnt == SAT_C) ? lowcnt : lowcnt + 1'b1;
  assign start_hit  = (st == ST_START) && line_in &&
                      (lowcnt >= MIN_C) && (lowcnt <= MAX_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      lowcnt <= '0;
      slot   <= '0;
      phase  <= 2'd0;
      quiet  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!line_in) begin
            st     <= ST_START;
            lowcnt <= CNT_W'(1);
          end else if (quiet && change) begin
            st <= ST_KICK;
          end
        end
        ST_KICK: begin
          st     <= line_in ? ST_IDLE : ST_START;
          lowcnt <= CNT_W'(1);
        end
        ST_START: begin
          if (!line_in) lowcnt <= lowcnt_inc;
          else if (start_hit) begin
            st    <= ST_FRAME;
            slot  <= '0;
            phase <= 2'd0;
          end else st <= ST_IDLE;
        end
        ST_FRAME: begin
          if (phase == 2'd2) begin
            phase <= 2'd0;
            if (slot == LAST_C) st <= ST_STOPW;
            else slot <= slot + 1'b1;
          end else phase <= phase + 2'd1;
        end
        ST_STOPW: begin
          if (!line_in) begin
            st     <= ST_STOP;
            lowcnt <= CNT_W'(1);
          end
        end
        ST_STOP: begin
          if (!line_in) lowcnt <= lowcnt_inc;
          else begin
            if (lowcnt == CNT_W'(2)) quiet <= 1'b1;
            else if (lowcnt >= CNT_W'(3)) quiet <= 1'b0;
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sirq_clkrun_ctl.sv
module sirq_clkrun_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic clkrun_in,
  input  logic restart_en,
  input  logic stop_inh_en,
  input  logic pending,
  input  logic busy,
  output logic drive
);
  logic want;
  assign want = (restart_en & pending) | (stop_inh_en & busy);

  // sticky once started so the agent's own low level does not release it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive <= 1'b0;
    else        drive <= want & (drive | clkrun_in);
  end
endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_pkg::*;
#(
  parameter int KBD_SLOT   = 1,
  parameter int MOUSE_SLOT = 12,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] soft_req,
  input  logic       obuf_full0,
  input  logic       obuf_full1,
  input  logic [2:0] hw_en,
  input  logic [4:0] user_sel,
  input  logic       restart_en,
  input  logic       stop_inh_en,
  input  logic       serirq_in,
  output logic       serirq_oe,
  output logic       serirq_out,
  input  logic       clkrun_in,
  output logic       clkrun_drive
);
  localparam slot_t KBD_C = slot_t'(KBD_SLOT);
  localparam slot_t MSE_C = slot_t'(MOUSE_SLOT);

  logic [NUM_SRC-1:0] lv, held_lv;
  slot_t              held_usr, slot;
  sirq_state_e        st;
  logic [1:0]         phase;
  logic quiet, start_hit, kick, in_frame, change;
  logic own_now, lvl_now, sample_low, recov_high;

  sirq_req_merge #(.N(NUM_SRC)) u_merge (
    .soft_req (soft_req),
    .hw_en    (hw_en),
    .flag_src ({obuf_full1, obuf_full0, obuf_full0}),
    .level    (lv)
  );

  assign change = (lv != held_lv);

  sirq_frame_seq #(
    .START_MIN (START_MIN),
    .START_MAX (START_MAX),
    .LAST_SLOT (TOTAL_SLOTS - 1)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (serirq_in),
    .change    (change),
    .st        (st),
    .slot      (slot),
    .phase     (phase),
    .quiet     (quiet),
    .start_hit (start_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_lv  <= '0;
      held_usr <= '0;
    end else if (start_hit) begin
      held_lv  <= lv;
      held_usr <= user_slot(user_sel);
    end
  end

  assign kick       = (st == ST_KICK);
  assign in_frame   = (st == ST_FRAME);
  assign own_now    = slot_owned(slot, held_usr, KBD_C, MSE_C);
  assign lvl_now    = slot_level(slot, held_usr, KBD_C, MSE_C, held_lv);
  assign sample_low = in_frame && phase == 2'd0 && own_now && !lvl_now;
  assign recov_high = in_frame && phase == 2'd1 && own_now && !lvl_now;

  assign serirq_oe  = kick | sample_low | recov_high;
  assign serirq_out = recov_high;

  sirq_clkrun_ctl u_clkrun (
    .clk         (clk),
    .rst_n       (rst_n),
    .clkrun_in   (clkrun_in),
    .restart_en  (restart_en),
    .stop_inh_en (stop_inh_en),
    .pending     (change),
    .busy        (st != ST_IDLE),
    .drive       (clkrun_drive)
  );
endmodule

// File: rtl/sirq_agent_chk.sv
module sirq_agent_chk
  import sirq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_frame,
  input logic               kick,
  input logic               quiet,
  input logic [1:0]         phase,
  input logic [NUM_SRC-1:0] held_lv,
  input logic               serirq_oe,
  input logic               serirq_out,
  input logic               clkrun_drive,
  input logic               restart_en,
  input logic               stop_inh_en
);
  p_kick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  p_kick_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> quiet);
  p_recovery_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && phase == 2'd0 && serirq_oe) |=> (serirq_oe && serirq_out));
  p_turnaround_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && phase == 2'd2) |-> !serirq_oe);
  p_drive_context_r6: assert property (@(posedge clk) disable iff (!rst_n)
    serirq_oe |-> (in_frame || kick));
  p_hold_levels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |=> $stable(held_lv));
  p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);
  p_clkrun_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clkrun_drive |-> $past(restart_en || stop_inh_en));
endmodule

bind sirq_agent sirq_agent_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_frame     (in_frame),
  .kick         (kick),
  .quiet        (quiet),
  .phase        (phase),
  .held_lv      (held_lv),
  .serirq_oe    (serirq_oe),
  .serirq_out   (serirq_out),
  .clkrun_drive (clkrun_drive),
  .restart_en   (restart_en),
  .stop_inh_en  (stop_inh_en)
);

// File: tb/sirq_agent_tb.sv
module sirq_agent_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] soft_req = 3'b000;
  logic       obuf_full0 = 1'b0, obuf_full1 = 1'b0;
  logic [2:0] hw_en = 3'b000;
  logic [4:0] user_sel = 5'd0;
  logic       restart_en = 1'b0, stop_inh_en = 1'b0;
  logic       clkrun_in = 1'b0;
  logic       host_low = 1'b0;
  logic       serirq_in, serirq_oe, serirq_out, clkrun_drive;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  // wired line with pull-up
  assign serirq_in = !((serirq_oe && !serirq_out) || host_low);

  sirq_agent u_dut (
    .clk (clk), .rst_n (rst_n), .soft_req (soft_req),
    .obuf_full0 (obuf_full0), .obuf_full1 (obuf_full1), .hw_en (hw_en),
    .user_sel (user_sel), .restart_en (restart_en), .stop_inh_en (stop_inh_en),
    .serirq_in (serirq_in), .serirq_oe (serirq_oe), .serirq_out (serirq_out),
    .clkrun_in (clkrun_in), .clkrun_drive (clkrun_drive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] exp_mask(input logic [2:0] s, input logic f0,
                                           input logic f1, input logic [2:0] en,
                                           input logic [4:0] sel);
    logic l0, l1, l2, ok;
    logic [26:0] m;
    l0 = s[0] | (f0 & en[0]);
    l1 = s[1] | (f0 & en[1]);
    l2 = s[2] | (f1 & en[2]);
    ok = (sel >= 5'd1) && (sel <= 5'd26);
    for (int k = 0; k < 27; k++) begin
      logic own, lvl;
      own  = (k == 1) || (k == 12) || (ok && k == int'(sel));
      lvl  = (k == 1 && l0) || (k == 12 && l1) || (ok && k == int'(sel) && l2);
      m[k] = own && !lvl;
    end
    return m;
  endfunction

  function automatic logic [26:0] cur_mask();
    return exp_mask(soft_req, obuf_full0, obuf_full1, hw_en, user_sel);
  endfunction

  // host runs a full cycle from the current negedge
  task automatic do_cycle(input int start_n, input int stop_n, input bit mid_en,
                          input logic [2:0] mid_soft, output logic [26:0] lows,
                          output logic [26:0] highs, output int bad_oe,
                          output logic ck_mid);
    bad_oe = 0; lows = '0; highs = '0; ck_mid = 1'b0;
    host_low = 1'b1;
    for (int i = 0; i < start_n; i++) begin
      @(negedge clk);
      if (serirq_oe) bad_oe++;
    end
    host_low = 1'b0;
    for (int s = 0; s < 27; s++) begin
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        if (p == 0) lows[s]  = serirq_oe && !serirq_out;
        if (p == 1) highs[s] = serirq_oe && serirq_out;
        if (p == 2 && serirq_oe) bad_oe++;
        if (p == 0 && s == 13) ck_mid = clkrun_drive;
        if (mid_en && s == 3 && p == 0) soft_req = mid_soft;
      end
    end
    @(negedge clk);
    host_low = 1'b1;
    repeat (stop_n) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
  endtask

  task automatic cycle_check(input string tag, input int start_n, input int stop_n);
    logic [26:0] lo, hi, em;
    int bo;
    logic ck;
    em = cur_mask();
    do_cycle(start_n, stop_n, 0, 3'b000, lo, hi, bo, ck);
    chk({tag, " sample lows"}, 32'(lo), 32'(em));
    chk({tag, " recovery highs"}, 32'(hi), 32'(em));
    chk({tag, " stray drive"}, 32'(bo), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 oe during reset", 32'(serirq_oe), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", 32'(serirq_oe), 32'd0);
    chk("R1 clkrun after reset", 32'(clkrun_drive), 32'd0);
    soft_req = 3'b001;
    begin
      int n = 0;
      repeat (6) begin @(negedge clk); if (serirq_oe) n++; end
      chk("R1 R9 no kick in continuous mode", 32'(n), 32'd0);
    end
    soft_req = 3'b000;
    @(negedge clk);
  endtask

  task automatic t_fixed_slots();
    obuf_full0 = 1'b1; hw_en = 3'b001;
    cycle_check("R2 R6 kbd by flag", 4, 3);
    hw_en = 3'b010;
    cycle_check("R3 R6 mouse by flag", 5, 3);
    hw_en = 3'b000;
    cycle_check("R2 R3 flag without enable", 4, 3);
    obuf_full0 = 1'b0; soft_req = 3'b011;
    cycle_check("R2 R3 soft bits", 6, 4);
    soft_req = 3'b000;
  endtask

  task automatic t_user_slot();
    user_sel = 5'd5;
    cycle_check("R4 user irq5", 8, 3);
    user_sel = 5'd26;
    cycle_check("R4 user ext10", 4, 3);
    obuf_full1 = 1'b1; hw_en = 3'b100;
    cycle_check("R4 user ext10 active", 4, 3);
    obuf_full1 = 1'b0; hw_en = 3'b000;
    user_sel = 5'd0;
    cycle_check("R4 sel zero", 7, 3);
    user_sel = 5'd30;
    cycle_check("R4 sel out of range", 4, 3);
    user_sel = 5'd12; soft_req = 3'b100;
    cycle_check("R12 shared mouse slot", 4, 3);
    user_sel = 5'd1; soft_req = 3'b010;
    cycle_check("R12 shared kbd slot low", 4, 3);
    user_sel = 5'd0; soft_req = 3'b000;
  endtask

  task automatic t_bad_start(input int len);
    int n = 0;
    host_low = 1'b1;
    repeat (len) @(negedge clk);
    host_low = 1'b0;
    repeat (90) begin @(negedge clk); if (serirq_oe) n++; end
    chk($sformatf("R5 start of %0d ignored", len), 32'(n), 32'd0);
  endtask

  task automatic t_mid_change();
    logic [26:0] lo, hi;
    int bo;
    logic ck;
    logic [26:0] em;
    em = cur_mask();
    do_cycle(4, 3, 1, 3'b010, lo, hi, bo, ck);
    chk("R7 held levels this cycle", 32'(lo), 32'(em));
    cycle_check("R7 change next cycle", 4, 3);
    soft_req = 3'b000;
    cycle_check("R7 restore", 4, 3);
  endtask

  task automatic t_quiet();
    int n = 0;
    cycle_check("R8 enter quiet", 4, 2);
    repeat (4) begin @(negedge clk); if (serirq_oe) n++; end
    chk("R9 quiet no change no kick", 32'(n), 32'd0);
    soft_req = 3'b001;
    @(negedge clk);
    chk("R9 kick drives low", 32'({serirq_oe, serirq_out}), 32'b10);
    cycle_check("R9 cycle after kick", 4, 3);
    soft_req = 3'b011;
    n = 0;
    repeat (6) begin @(negedge clk); if (serirq_oe) n++; end
    chk("R8 back to continuous no kick", 32'(n), 32'd0);
    cycle_check("R8 report after continuous", 4, 3);
    soft_req = 3'b000;
    cycle_check("R8 settle", 4, 3);
  endtask

  task automatic t_clkrun();
    logic [26:0] lo, hi;
    int bo;
    logic ck;
    restart_en = 1'b1; clkrun_in = 1'b1;
    @(negedge clk);
    chk("R10 no pending no drive", 32'(clkrun_drive), 32'd0);
    soft_req = 3'b100;
    @(negedge clk);
    chk("R10 restart request", 32'(clkrun_drive), 32'd1);
    clkrun_in = 1'b0;
    @(negedge clk);
    chk("R10 held after clock runs", 32'(clkrun_drive), 32'd1);
    restart_en = 1'b0;
    @(negedge clk);
    chk("R10 released when disabled", 32'(clkrun_drive), 32'd0);
    restart_en = 1'b1;
    @(negedge clk);
    chk("R10 no start while clock runs", 32'(clkrun_drive), 32'd0);
    restart_en = 1'b0; soft_req = 3'b000;
    stop_inh_en = 1'b1; clkrun_in = 1'b1;
    @(negedge clk);
    chk("R11 idle no hold-off", 32'(clkrun_drive), 32'd0);
    do_cycle(4, 3, 0, 3'b000, lo, hi, bo, ck);
    chk("R11 hold-off mid cycle", 32'(ck), 32'd1);
    @(negedge clk);
    chk("R11 released after cycle", 32'(clkrun_drive), 32'd0);
    stop_inh_en = 1'b0; clkrun_in = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fixed_slots();
    t_user_slot();
    t_bad_start(3);
    t_bad_start(9);
    t_mid_change();
    t_quiet();
    t_clkrun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule